// File: doc/BRIEF.md
# Double Late Write Pipelined SRAM

This block is a synthesizable synchronous static memory whose write data trail the write command by two clock edges, while read data leave through a registered output stage one edge after the read command. Every control input (address, read/write select, three chip enables and the per-byte write enables) is sampled on the rising clock edge. A write command names its bytes at command time; the data word arrives on the data-in port two edges later and is committed on that edge. A read command's result is placed in the same cycle slot in which a write command's data would be presented, so alternating reads and writes keep the data path busy every cycle with no turnaround gap.

Words are built from 9-bit bytes with one active-low write enable per byte. A write with no byte enabled is an abort that leaves the array alone. Because a write is still in flight for two cycles, a read that targets the same address sees the new bytes merged over the stored word, so the read and write pipelines stay coherent. The output driver follows a dual-cycle-deselect rule: the output-enable flag stands in for the high-impedance state and is raised only for the slot of a selected read, then dropped. An echo strobe accompanies the data slots and is governed by the two bank-style enables, not by the primary chip enable.

The output driver is a two-state machine. State HIZ (output-enable low, data zero) moves to DRIVE on an edge whose sampled command in stage one is a selected read; DRIVE stays in DRIVE on another such edge and returns to HIZ on any other edge, which is how a deselect lets the last read finish before the output goes quiet. Stage-one commands are classified as NONE, READ, WRITE or ABORT.

Top module: `dlw_sram`

## Requirements
- R1: After reset the output-enable flag, the echo strobe and the data output are all low, and every word of the array reads back as zero.
- R2: A command takes effect only when, at its rising edge, ce1_n is low, ce2 is high and ce3_n is low; otherwise the cycle is a no-operation that neither writes nor reads.
- R3: For a selected write (we_n low) sampled at edge k, the word on din at edge k+2 is stored, byte i being bits [9i+8:9i] and written only when bw_n[i] is low at edge k.
- R4: A selected write with every bw_n bit high is an abort: the addressed word is unchanged.
- R5: When we_n is high the command is a read and bw_n has no effect on the array or on the data returned.
- R6: For a selected read at edge k, dout carries the addressed word and dout_oe is high from edge k+1 until edge k+2.
- R7: A read issued one or more cycles after a write to the same address returns the written bytes merged over the older word, even while the write data have not yet been committed.
- R8: dout_oe is high only in the slot following a selected read; after a deselect the pending read's slot completes and dout_oe falls at the next edge; dout is zero whenever dout_oe is low.
- R9: echo is high from edge k+1 to k+2 exactly when ce2 was high and ce3_n low at edge k, whatever ce1_n and we_n were; so it stays on through a deselect by ce1_n alone.
- R10: Alternating selected read and write commands give a read data slot in every other cycle and write data slots in between, with no idle cycle inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears array and pipeline |
| addr | input | AW (6) | Word address |
| we_n | input | 1 | Low selects write, high selects read |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Bank enable, active high; also gates the echo strobe |
| ce3_n | input | 1 | Bank enable, active low; also gates the echo strobe |
| bw_n | input | NB (4) | Per-byte write enables, active low |
| din | input | W (36) | Write data, sampled two edges after the write command |
| dout | output | W (36) | Registered read data, zero when not driving |
| dout_oe | output | 1 | Output-enable flag replacing the high-impedance state |
| echo | output | 1 | Echo strobe accompanying the data slots |

## Verification
The embedded assertions watch on every cycle that dout_oe only follows a selected read two edges back, that the echo strobe covers every driven slot and follows the bank enables, that the output is zero while not driving, and that a stage-two write always came from a write with live byte enables. Only the bench's scenarios can show the data themselves: the two-cycle data lag with partial byte masks, aborts that leave words untouched, reads that ignore their byte enables, forwarding of an uncommitted write into a back-to-back read, and the dense alternating read/write stream, all compared against a behavioural reference array every clock.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

    typedef enum logic [1:0] {
        SK_NONE  = 2'd0,
        SK_READ  = 2'd1,
        SK_WRITE = 2'd2,
        SK_ABORT = 2'd3
    } slot_kind_e;

    typedef enum logic {
        ST_HIZ   = 1'b0,
        ST_DRIVE = 1'b1
    } drv_state_e;

endpackage

// File: rtl/dlw_cmd_pipe.sv
module dlw_cmd_pipe
    import dlw_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    input  logic                 we_n,
    input  logic                 ce1_n,
    input  logic                 ce2,
    input  logic                 ce3_n,
    input  logic [NB-1:0]        bw_n,
    output slot_kind_e           s1_kind,
    output logic [AW-1:0]        s1_addr,
    output logic                 s1_echo,
    output slot_kind_e           s2_kind,
    output logic [AW-1:0]        s2_addr,
    output logic [NB-1:0]        s2_bw_n
);

    logic          selected;
    slot_kind_e    cmd_kind;
    logic [NB-1:0] s1_bw_n;

    always_comb begin
        selected = !ce1_n && ce2 && !ce3_n;
        if (!selected) begin
            cmd_kind = SK_NONE;
        end else if (we_n) begin
            cmd_kind = SK_READ;
        end else if (&bw_n) begin
            cmd_kind = SK_ABORT;
        end else begin
            cmd_kind = SK_WRITE;
        end
    end

    // stage one: the command edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_kind <= SK_NONE;
            s1_addr <= '0;
            s1_bw_n <= '1;
            s1_echo <= 1'b0;
        end else begin
            s1_kind <= cmd_kind;
            s1_addr <= addr;
            s1_bw_n <= bw_n;
            s1_echo <= ce2 && !ce3_n;
        end
    end

    // stage two: write waiting for its data edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_kind <= SK_NONE;
            s2_addr <= '0;
            s2_bw_n <= '1;
        end else begin
            s2_kind <= s1_kind;
            s2_addr <= s1_addr;
            s2_bw_n <= s1_bw_n;
        end
    end

    AST_WRITE_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_kind == SK_WRITE) |-> $past(!we_n && !(&bw_n), 2)); // R3

endmodule

// File: rtl/dlw_array.sv
module dlw_array #(
    parameter int DEPTH = 64,
    parameter int NB    = 4,
    parameter int BW    = 9,
    localparam int W    = NB * BW,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [NB-1:0] wr_be_n,
    input  logic [W-1:0]  wr_data
);

    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] merged;

    assign rd_data = mem[rd_addr];

    always_comb begin
        merged = mem[wr_addr];
        for (int b = 0; b < NB; b++) begin
            if (!wr_be_n[b]) begin
                merged[b*BW +: BW] = wr_data[b*BW +: BW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= merged;
        end
    end

endmodule

// File: rtl/dlw_fwd.sv
module dlw_fwd
    import dlw_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 9,
    localparam int W = NB * BW
) (
    input  logic [AW-1:0] rd_addr,
    input  logic [W-1:0]  arr_word,
    input  slot_kind_e    pend_kind,
    input  logic [AW-1:0] pend_addr,
    input  logic [NB-1:0] pend_be_n,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  fwd_word
);

    logic hit;

    assign hit = (pend_kind == SK_WRITE) && (pend_addr == rd_addr);

    // the pending write commits on the same edge the read result is registered
    generate
        for (genvar b = 0; b < NB; b++) begin : g_byte
            assign fwd_word[b*BW +: BW] = (hit && !pend_be_n[b]) ? din[b*BW +: BW]
                                                                : arr_word[b*BW +: BW];
        end
    endgenerate

endmodule

// File: rtl/dlw_out_stage.sv
module dlw_out_stage
    import dlw_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  slot_kind_e   s1_kind,
    input  logic         s1_echo,
    input  logic [W-1:0] rd_word,
    output logic [W-1:0] dout,
    output logic         dout_oe,
    output logic         echo
);

    drv_state_e state_q;
    drv_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_HIZ:   state_d = (s1_kind == SK_READ) ? ST_DRIVE : ST_HIZ;
            ST_DRIVE: state_d = (s1_kind == SK_READ) ? ST_DRIVE : ST_HIZ;
            default:  state_d = ST_HIZ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HIZ;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
            echo <= 1'b0;
        end else begin
            dout <= (state_d == ST_DRIVE) ? rd_word : '0;
            echo <= s1_echo;
        end
    end

    assign dout_oe = (state_q == ST_DRIVE);

    AST_OE_NEEDS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> echo); // R9

    AST_QUIET_WHEN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0)); // R8

endmodule

// File: rtl/dlw_sram.sv
module dlw_sram
    import dlw_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NB    = 4,
    parameter int BW    = 9,
    localparam int W    = NB * BW,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we_n,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic [NB-1:0] bw_n,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic          dout_oe,
    output logic          echo
);

    slot_kind_e    s1_kind;
    slot_kind_e    s2_kind;
    logic [AW-1:0] s1_addr;
    logic [AW-1:0] s2_addr;
    logic          s1_echo;
    logic [NB-1:0] s2_bw_n;
    logic [W-1:0]  arr_word;
    logic [W-1:0]  rd_word;
    logic          arr_wr_en;

    dlw_cmd_pipe #(.AW(AW), .NB(NB)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .we_n    (we_n),
        .ce1_n   (ce1_n),
        .ce2     (ce2),
        .ce3_n   (ce3_n),
        .bw_n    (bw_n),
        .s1_kind (s1_kind),
        .s1_addr (s1_addr),
        .s1_echo (s1_echo),
        .s2_kind (s2_kind),
        .s2_addr (s2_addr),
        .s2_bw_n (s2_bw_n)
    );

    assign arr_wr_en = (s2_kind == SK_WRITE);

    dlw_array #(.DEPTH(DEPTH), .NB(NB), .BW(BW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (s1_addr),
        .rd_data (arr_word),
        .wr_en   (arr_wr_en),
        .wr_addr (s2_addr),
        .wr_be_n (s2_bw_n),
        .wr_data (din)
    );

    dlw_fwd #(.AW(AW), .NB(NB), .BW(BW)) u_fwd (
        .rd_addr   (s1_addr),
        .arr_word  (arr_word),
        .pend_kind (s2_kind),
        .pend_addr (s2_addr),
        .pend_be_n (s2_bw_n),
        .din       (din),
        .fwd_word  (rd_word)
    );

    dlw_out_stage #(.W(W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .s1_kind (s1_kind),
        .s1_echo (s1_echo),
        .rd_word (rd_word),
        .dout    (dout),
        .dout_oe (dout_oe),
        .echo    (echo)
    );

    AST_OE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> $past(!ce1_n && ce2 && !ce3_n && we_n, 2)); // R6

    AST_ECHO_FROM_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        echo |-> $past(ce2 && !ce3_n, 2)); // R9

endmodule

// File: tb/sim_dlw_sram.sv
`timescale 1ns/1ps
module sim_dlw_sram;

    localparam int DEPTH = 64;
    localparam int NB    = 4;
    localparam int BW    = 9;
    localparam int W     = NB * BW;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we_n = 1'b1;
    logic          ce1_n = 1'b1;
    logic          ce2 = 1'b0;
    logic          ce3_n = 1'b1;
    logic [NB-1:0] bw_n = '1;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  dout;
    logic          dout_oe;
    logic          echo;

    int compared = 0;
    int mismatched = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [W-1:0] ref_mem [DEPTH];
    int           h1_kind = 0, h2_kind = 0;
    int           h1_addr = 0, h2_addr = 0;
    bit           h1_echo = 1'b0;
    logic [NB-1:0] h1_bw = '1, h2_bw = '1;
    bit           exp_oe = 1'b0;
    bit           exp_echo = 1'b0;
    logic [W-1:0] exp_dout = '0;

    always #4 clk = ~clk;

    dlw_sram u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we_n(we_n), .ce1_n(ce1_n),
        .ce2(ce2), .ce3_n(ce3_n), .bw_n(bw_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .echo(echo)
    );

    // behavioural model: 0 none, 1 read, 2 write, 3 abort
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
            h1_kind = 0; h2_kind = 0; h1_echo = 1'b0;
            exp_oe = 1'b0; exp_echo = 1'b0; exp_dout = '0;
        end else begin
            if (h2_kind == 2) begin
                for (int b = 0; b < NB; b++)
                    if (!h2_bw[b]) ref_mem[h2_addr][b*BW +: BW] = din[b*BW +: BW];
            end
            exp_oe   = (h1_kind == 1);
            exp_dout = (h1_kind == 1) ? ref_mem[h1_addr] : '0;
            exp_echo = h1_echo;
            h2_kind = h1_kind; h2_addr = h1_addr; h2_bw = h1_bw;
            if (!(!ce1_n && ce2 && !ce3_n)) h1_kind = 0;
            else if (we_n) h1_kind = 1;
            else if (&bw_n) h1_kind = 3;
            else h1_kind = 2;
            h1_addr = int'(addr);
            h1_bw   = bw_n;
            h1_echo = ce2 && !ce3_n;
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            compared++;
            if (dout_oe !== exp_oe || echo !== exp_echo || dout !== exp_dout) begin
                mismatched++;
                $display("FAIL %s: oe/echo/dout actual %b/%b/%h expected %b/%b/%h",
                         cur_req, dout_oe, echo, dout, exp_oe, exp_echo, exp_dout);
            end
        end
    end

    task automatic step(input int a, input bit wn, input bit c1n, input bit c2,
                        input bit c3n, input logic [NB-1:0] bw);
        @(negedge clk);
        addr  = a[AW-1:0];
        we_n  = wn;
        ce1_n = c1n;
        ce2   = c2;
        ce3_n = c3n;
        bw_n  = bw;
        din   = W'({$urandom(), $urandom()});
    endtask

    task automatic rd(input int a, input logic [NB-1:0] bw);
        step(a, 1'b1, 1'b0, 1'b1, 1'b0, bw);
    endtask

    task automatic wr(input int a, input logic [NB-1:0] bw);
        step(a, 1'b0, 1'b0, 1'b1, 1'b0, bw);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 1'b1, 1'b1, 1'b0, 1'b1, '1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state seen at the ports
        @(negedge clk);
        compared++;
        if (dout_oe !== 1'b0 || echo !== 1'b0 || dout !== '0) begin
            mismatched++;
            $display("FAIL R1: oe/echo/dout actual %b/%b/%h expected 0/0/0", dout_oe, echo, dout);
        end
        rst_n = 1'b1;
        chk_on = 1'b1;

        cur_req = "R1";
        for (int a = 0; a < 8; a++) rd(a, '1);
        idle(3);

        cur_req = "R3";
        for (int a = 0; a < 6; a++) wr(a, 4'b0000);
        idle(2);
        for (int a = 0; a < 6; a++) rd(a, '1);
        wr(1, 4'b1110); wr(2, 4'b0101); wr(3, 4'b0111);
        idle(3);
        for (int a = 1; a < 4; a++) rd(a, '1);
        idle(2);

        cur_req = "R4";
        wr(4, 4'b1111); wr(5, 4'b1111);
        idle(3);
        rd(4, '1); rd(5, '1);
        idle(2);

        cur_req = "R5";
        rd(0, 4'b0000); rd(1, 4'b1010); rd(0, '1); rd(1, '1);
        idle(2);

        cur_req = "R7";
        wr(9, 4'b0000); rd(9, '1); rd(9, '1);
        wr(9, 4'b0110); wr(9, 4'b1001); rd(9, '1); rd(9, '1);
        wr(10, 4'b0011); idle(1); rd(10, '1);
        idle(3);

        cur_req = "R8";
        rd(2, '1);
        step(2, 1'b1, 1'b1, 1'b1, 1'b0, '1);
        step(2, 1'b1, 1'b1, 1'b1, 1'b0, '1);
        rd(3, '1); rd(4, '1);
        step(3, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000);
        idle(3);

        cur_req = "R9";
        step(1, 1'b1, 1'b1, 1'b1, 1'b0, '1);
        step(1, 1'b1, 1'b0, 1'b0, 1'b0, '1);
        step(1, 1'b1, 1'b0, 1'b1, 1'b1, '1);
        step(1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000);
        idle(3);

        cur_req = "R2";
        step(6, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000);
        step(7, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000);
        step(8, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0000);
        idle(3);
        rd(6, '1); rd(7, '1); rd(8, '1);
        idle(2);

        cur_req = "R10";
        for (int i = 0; i < 12; i++) begin
            if (i % 2 == 0) rd(i % 4, '1);
            else wr(i % 4, 4'b0000);
        end
        idle(3);

        cur_req = "R6";
        for (int i = 0; i < 400; i++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 4) rd($urandom_range(0, 5), 4'($urandom()));
            else if (k < 8) wr($urandom_range(0, 5), 4'($urandom()));
            else if (k == 8) step($urandom_range(0, 5), 1'($urandom()), 1'b1, 1'b1, 1'b0, '1);
            else idle(1);
        end
        idle(3);
        for (int a = 0; a < 12; a++) rd(a, '1);
        idle(3);

        chk_on = 1'b0;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule